// File: doc/BRIEF.md
# Indirect Subsystem Register Bridge

This block gives a host on a simple 32-bit register bus a way to reach a byte-wide register file that sits in a slower subsystem. The host cannot address the subsystem registers directly. It first writes a command word into a control register, which names the subsystem register and the transfer direction. A read is started by that control write. A write is started by the following write to the lower data register. While a transfer runs, a busy bit in the control word stays set, and the host polls it. The crossing into the slow domain is modelled as a fixed transfer latency, set by the parameter `XFER_LAT`.

The bridge also collects two interrupt sources into a flag register with write-one-to-clear bits and a matching enable register. The sources are the subsystem's own interrupt line and the end of each bridge transfer. A single interrupt output is raised while any enabled flag is set. A read-only identification word at offset 0x00 lets software confirm which block it has found.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the control word, the lower data register, the flags and the enables all read 0, busy (control bit 31) is 0 and `irq` is low.
- R2: Offset 0x00 always reads the parameter `ID_VALUE`, and host writes to it change nothing.
- R3: A control write (offset 0x04) with direction bit 24 = 1 starts a read. Busy then reads 1 for exactly `XFER_LAT` cycles, and exactly one `sub_rd` strobe is issued, in the last busy cycle.
- R4: When a read completes, the lower data register (offset 0x08) holds the fetched byte in bits 7:0 with bits 31:8 zero.
- R5: A control write with bit 24 = 0 does not set busy. The next write to offset 0x08 starts the transfer: busy reads 1 for `XFER_LAT` cycles, and one `sub_wr` strobe carries bits 7:0 of that data to the address in control bits 7:0.
- R6: Host writes to the control or lower data register are ignored while busy is set.
- R7: A transfer whose low lane enable (control bit 16) is 0 still shows busy for `XFER_LAT` cycles, but issues no subsystem strobe and leaves the lower data register unchanged.
- R8: Flag bit 0 is set when any transfer completes. Flag bit 1 is set on a rising edge of `sub_irq` only, so a level held high does not set it again once it has been cleared.
- R9: Writing 1 to a bit of the flag register (offset 0x14) clears that flag, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: `irq` is high exactly when some flag bit and the enable bit at the same position (offset 0x10, bits 1:0) are both 1.
- R11: The control word reads back size (bit 25), direction (bit 24), upper lane enables (bits 23:20), lower lane enables (bits 19:16) and address (bits 7:0), with all other bits except busy at 0. Offset 0x0C is a 32-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from the offset |
| sub_addr | output | 8 | Subsystem register address |
| sub_wdata | output | 8 | Subsystem write byte |
| sub_wr | output | 1 | Subsystem write strobe, one cycle |
| sub_rd | output | 1 | Subsystem read strobe, one cycle; `sub_rdata` is taken in the same cycle |
| sub_rdata | input | 8 | Subsystem read data |
| sub_irq | input | 1 | Subsystem interrupt level |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the bridge with `XFER_LAT` = 3 and a non-default `ID_VALUE`. A short latency keeps each busy window a few cycles long, so the exact count of busy cycles can be measured by polling. It also lets two host writes land inside one window, which exercises the rule that writes during busy are ignored. The distinct identification constant shows that offset 0x00 returns the parameter and not a value built into the logic.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  localparam int HOST_AW = 8;
  localparam int HOST_DW = 32;
  localparam int SUB_AW  = 8;
  localparam int SUB_DW  = 8;
  localparam int N_IRQ   = 2;

  // host register offsets
  localparam logic [HOST_AW-1:0] OFS_IDENT = 8'h00;
  localparam logic [HOST_AW-1:0] OFS_CMD   = 8'h04;
  localparam logic [HOST_AW-1:0] OFS_DLO   = 8'h08;
  localparam logic [HOST_AW-1:0] OFS_DHI   = 8'h0C;
  localparam logic [HOST_AW-1:0] OFS_IEN   = 8'h10;
  localparam logic [HOST_AW-1:0] OFS_IFLG  = 8'h14;

  // command word bit positions
  localparam int CMD_BUSY_BIT = 31;
  localparam int CMD_SIZE_BIT = 25;
  localparam int CMD_DIR_BIT  = 24;
  localparam int CMD_LANEU_LO = 20;
  localparam int CMD_LANEL_LO = 16;

  // interrupt source positions
  localparam int IRQ_XFER = 0;
  localparam int IRQ_SUB  = 1;

  typedef struct packed {
    logic              size;
    logic              dir;
    logic [3:0]        lane_u;
    logic [3:0]        lane_l;
    logic [SUB_AW-1:0] addr;
  } cmd_t;

endpackage

// File: rtl/ibr_xfer_engine.sv
module ibr_xfer_engine
  import ibr_pkg::*;
#(
  parameter int XFER_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              dir_rd,
  input  logic              lane0_en,
  input  logic [SUB_DW-1:0] sub_rdata,
  output logic              busy,
  output logic              done,
  output logic              sub_wr,
  output logic              sub_rd,
  output logic              rd_valid,
  output logic [SUB_DW-1:0] rd_byte
);

  localparam int CNT_W = (XFER_LAT > 1) ? $clog2(XFER_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_LAT - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next state
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!busy_q && launch) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy     = busy_q;
  assign done     = busy_q && (cnt_q == '0);
  assign sub_rd   = done && dir_rd && lane0_en;
  assign sub_wr   = done && !dir_rd && lane0_en;
  assign rd_valid = sub_rd;
  assign rd_byte  = sub_rdata;

endmodule

// File: rtl/ibr_irq_unit.sv
module ibr_irq_unit
  import ibr_pkg::*;
#(
  parameter int NSRC = N_IRQ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_we,
  input  logic            en_we,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] enables,
  output logic            irq
);

  logic [NSRC-1:0] flag_q, flag_d;
  logic [NSRC-1:0] en_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_comb begin
      if (evt[g])                    flag_d[g] = 1'b1;
      else if (clr_we && wbits[g])   flag_d[g] = 1'b0;
      else                           flag_d[g] = flag_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_we) en_q <= wbits;
    end
  end

  assign flags   = flag_q;
  assign enables = en_q;
  assign irq     = |(flag_q & en_q);

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int              XFER_LAT = 4,
  parameter logic [31:0]     ID_VALUE = 32'h1B51_0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic [SUB_AW-1:0]  sub_addr,
  output logic [SUB_DW-1:0]  sub_wdata,
  output logic               sub_wr,
  output logic               sub_rd,
  input  logic [SUB_DW-1:0]  sub_rdata,
  input  logic               sub_irq,
  output logic               irq
);

  cmd_t               cmd_q, cmd_d;
  logic [HOST_DW-1:0] dlo_q, dlo_d;
  logic [HOST_DW-1:0] dhi_q;
  logic               sub_irq_q;

  logic busy, done, rd_valid;
  logic [SUB_DW-1:0] rd_byte;
  logic [N_IRQ-1:0]  flags, enables, evt;

  logic host_we, we_cmd, we_dlo, we_dhi, we_ien, we_iflg;
  logic launch_rd, launch_wr;

  assign host_we  = host_sel && host_wr;
  assign we_cmd   = host_we && (host_addr == OFS_CMD) && !busy;
  assign we_dlo   = host_we && (host_addr == OFS_DLO) && !busy;
  assign we_dhi   = host_we && (host_addr == OFS_DHI);
  assign we_ien   = host_we && (host_addr == OFS_IEN);
  assign we_iflg  = host_we && (host_addr == OFS_IFLG);

  assign launch_rd = we_cmd && host_wdata[CMD_DIR_BIT];
  assign launch_wr = we_dlo && !cmd_q.dir;

  // next state for host-visible data registers
  always_comb begin
    cmd_d = cmd_q;
    if (we_cmd) begin
      cmd_d.size   = host_wdata[CMD_SIZE_BIT];
      cmd_d.dir    = host_wdata[CMD_DIR_BIT];
      cmd_d.lane_u = host_wdata[CMD_LANEU_LO +: 4];
      cmd_d.lane_l = host_wdata[CMD_LANEL_LO +: 4];
      cmd_d.addr   = host_wdata[SUB_AW-1:0];
    end
  end

  always_comb begin
    dlo_d = dlo_q;
    if (rd_valid)    dlo_d = {{(HOST_DW-SUB_DW){1'b0}}, rd_byte};
    else if (we_dlo) dlo_d = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      dlo_q     <= '0;
      dhi_q     <= '0;
      sub_irq_q <= 1'b0;
    end else begin
      if (we_cmd)             cmd_q <= cmd_d;
      if (rd_valid || we_dlo) dlo_q <= dlo_d;
      if (we_dhi)             dhi_q <= host_wdata;
      sub_irq_q <= sub_irq;
    end
  end

  ibr_xfer_engine #(
    .XFER_LAT (XFER_LAT)
  ) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch_rd || launch_wr),
    .dir_rd    (cmd_q.dir),
    .lane0_en  (cmd_q.lane_l[0]),
    .sub_rdata (sub_rdata),
    .busy      (busy),
    .done      (done),
    .sub_wr    (sub_wr),
    .sub_rd    (sub_rd),
    .rd_valid  (rd_valid),
    .rd_byte   (rd_byte)
  );

  assign sub_addr  = cmd_q.addr;
  assign sub_wdata = dlo_q[SUB_DW-1:0];

  always_comb begin
    evt           = '0;
    evt[IRQ_XFER] = done;
    evt[IRQ_SUB]  = sub_irq && !sub_irq_q;
  end

  ibr_irq_unit #(
    .NSRC (N_IRQ)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .clr_we  (we_iflg),
    .en_we   (we_ien),
    .wbits   (host_wdata[N_IRQ-1:0]),
    .flags   (flags),
    .enables (enables),
    .irq     (irq)
  );

  // host read mux
  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      OFS_IDENT: host_rdata = ID_VALUE;
      OFS_CMD: begin
        host_rdata[CMD_BUSY_BIT]          = busy;
        host_rdata[CMD_SIZE_BIT]          = cmd_q.size;
        host_rdata[CMD_DIR_BIT]           = cmd_q.dir;
        host_rdata[CMD_LANEU_LO +: 4]     = cmd_q.lane_u;
        host_rdata[CMD_LANEL_LO +: 4]     = cmd_q.lane_l;
        host_rdata[SUB_AW-1:0]            = cmd_q.addr;
      end
      OFS_DLO:  host_rdata = dlo_q;
      OFS_DHI:  host_rdata = dhi_q;
      OFS_IEN:  host_rdata[N_IRQ-1:0] = enables;
      OFS_IFLG: host_rdata[N_IRQ-1:0] = flags;
      default:  host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk
  import ibr_pkg::*;
#(
  parameter int XFER_LAT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               sub_rd,
  input logic               sub_wr,
  input cmd_t               cmd_q,
  input logic [HOST_DW-1:0] dlo_q,
  input logic               sub_irq,
  input logic [N_IRQ-1:0]   flags
);

  localparam int RUN_W = $clog2(XFER_LAT + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R3 / R5: busy window length equals the latency
  a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RUN_W'(XFER_LAT)));

  // R3: never both strobes together
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sub_rd, sub_wr}));

  // R5: a strobe closes the busy window
  a_r5_strobe_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_rd || sub_wr) |=> !busy);

  // R6: command word held while busy
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));

  // R4: read result is zero-filled above the byte
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rd |=> (dlo_q[HOST_DW-1:SUB_DW] == '0));

  // R8: rising subsystem interrupt sets its flag
  a_r8_sub_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_irq) |=> flags[IRQ_SUB]);

endmodule

bind ibr_bridge ibr_bridge_chk #(.XFER_LAT(XFER_LAT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .sub_rd  (sub_rd),
  .sub_wr  (sub_wr),
  .cmd_q   (cmd_q),
  .dlo_q   (dlo_q),
  .sub_irq (sub_irq),
  .flags   (flags)
);

// File: tb/ibr_bridge_tb.sv
module ibr_bridge_tb;

  localparam int          LAT = 3;
  localparam logic [31:0] IDV = 32'h5A17_0003;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h10, 32'h0000_0003, 32'h0,          8'd10}, // R10 enable write
    '{1'b0, 8'h10, 32'h0,          32'h0000_0003, 8'd10}, // R10 enable readback
    '{1'b1, 8'h10, 32'h0000_0000, 32'h0,          8'd10}, // R10 enables off
    '{1'b1, 8'h0C, 32'hDEAD_BEEF, 32'h0,          8'd11}, // R11 upper data write
    '{1'b0, 8'h0C, 32'h0,          32'hDEAD_BEEF, 8'd11}, // R11 upper data read
    '{1'b0, 8'h00, 32'h0,          IDV,           8'd2},  // R2 id read
    '{1'b1, 8'h00, 32'h1234_5678, 32'h0,          8'd2},  // R2 id write
    '{1'b0, 8'h00, 32'h0,          IDV,           8'd2},  // R2 id unchanged
    '{1'b1, 8'h04, 32'h02A5_1142, 32'h0,          8'd11}, // R11 command write, no launch
    '{1'b0, 8'h04, 32'h0,          32'h02A5_0042, 8'd11}  // R11 layout readback
  };

  logic        clk, rst_n;
  logic        host_sel, host_wr;
  logic [7:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic [7:0]  sub_addr, sub_wdata, sub_rdata;
  logic        sub_wr, sub_rd, sub_irq, irq;

  int errors = 0;
  int checks = 0;
  int n_rd = 0;
  int n_wr = 0;
  logic [7:0] mem [256];

  ibr_bridge #(.XFER_LAT(LAT), .ID_VALUE(IDV)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sub_addr(sub_addr), .sub_wdata(sub_wdata), .sub_wr(sub_wr), .sub_rd(sub_rd),
    .sub_rdata(sub_rdata), .sub_irq(sub_irq), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign sub_rdata = mem[sub_addr];

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
  end

  always @(posedge clk) begin
    if (sub_wr) mem[sub_addr] <= sub_wdata;
    if (sub_rd) n_rd <= n_rd + 1;
    if (sub_wr) n_wr <= n_wr + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start right after a falling edge and end at the next one
  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    #2;
    d = host_rdata;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    do begin
      hrd(8'h04, v);
      if (v[31]) n++;
    end while (v[31] && n < 100);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, rd0, wr0;
    rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_addr = '0;
    host_wdata = '0; sub_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    hrd(8'h04, v); check("R1 command", v, 32'h0);
    hrd(8'h08, v); check("R1 lower data", v, 32'h0);
    hrd(8'h14, v); check("R1 flags", v, 32'h0);
    hrd(8'h10, v); check("R1 enables", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) hwr(VECS[i].addr, VECS[i].data);
      else begin
        hrd(VECS[i].addr, v);
        check($sformatf("R%0d table[%0d]", VECS[i].req, i), v, VECS[i].exp);
      end
    end

    // R5 write transfer
    hwr(8'h04, 32'h0001_0020);
    hrd(8'h04, v); check("R5 no launch on command", {31'h0, v[31]}, 32'h0);
    wr0 = n_wr;
    hwr(8'h08, 32'hAABB_CC5A);
    wait_idle(n); check("R5 busy cycles", n, LAT);
    check("R5 one write strobe", n_wr - wr0, 1);
    check("R5 byte stored", {24'h0, mem[8'h20]}, 32'h5A);

    // R3 R4 read transfer
    rd0 = n_rd;
    hwr(8'h04, 32'h0101_0015);
    wait_idle(n); check("R3 busy cycles", n, LAT);
    check("R3 one read strobe", n_rd - rd0, 1);
    hrd(8'h08, v); check("R4 zero-filled byte", v, 32'h0000_00B0);

    // R5 readback of written byte
    hwr(8'h04, 32'h0101_0020);
    wait_idle(n);
    hrd(8'h08, v); check("R5 readback", v, 32'h0000_005A);

    // R6 writes ignored while busy
    rd0 = n_rd;
    hwr(8'h04, 32'h0101_0030);
    hwr(8'h04, 32'h0101_0031);
    hwr(8'h08, 32'h0000_0011);
    wait_idle(n);
    hrd(8'h08, v); check("R6 data from first command", v, 32'h0000_0095);
    hrd(8'h04, v); check("R6 address kept", {24'h0, v[7:0]}, 32'h30);
    check("R6 single strobe", n_rd - rd0, 1);

    // R7 low lane disabled
    rd0 = n_rd;
    hwr(8'h04, 32'h0100_0040);
    wait_idle(n); check("R7 busy cycles", n, LAT);
    check("R7 no strobe", n_rd - rd0, 0);
    hrd(8'h08, v); check("R7 data unchanged", v, 32'h0000_0095);

    // R8 R9 R10 transfer flag
    hrd(8'h14, v); check("R8 transfer flag", v, 32'h1);
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    hwr(8'h10, 32'h1);
    check("R10 irq enabled", {31'h0, irq}, 32'h1);
    hwr(8'h14, 32'h0);
    hrd(8'h14, v); check("R9 zero write keeps flag", v, 32'h1);
    hwr(8'h14, 32'h1);
    hrd(8'h14, v); check("R9 flag cleared", v, 32'h0);
    check("R10 irq after clear", {31'h0, irq}, 32'h0);

    // R8 subsystem edge
    sub_irq = 1'b1;
    @(negedge clk);
    hrd(8'h14, v); check("R8 sub flag set", v, 32'h2);
    hwr(8'h14, 32'h2);
    repeat (2) @(negedge clk);
    hrd(8'h14, v); check("R8 level does not re-set", v, 32'h0);
    hwr(8'h10, 32'h2);
    check("R10 no flag no irq", {31'h0, irq}, 32'h0);
    sub_irq = 1'b0;
    @(negedge clk);
    sub_irq = 1'b1;
    @(negedge clk);
    check("R10 sub irq raised", {31'h0, irq}, 32'h1);

    // R1 reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    sub_irq = 1'b0;
    @(negedge clk);
    hrd(8'h04, v); check("R1 command after reset", v, 32'h0);
    hrd(8'h10, v); check("R1 enables after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule